// File: doc/BRIEF.md
# Queue Status Interrupt Controller

This block turns the status flags of 64 hardware queues into two interrupt lines. The queues fall into a lower group of 32 and an upper group of 32. Every lower queue has four status flags: empty, nearly empty, nearly full and full. A 3-bit source setting per lower queue picks one of those flags and can invert it. Every upper queue interrupts on one fixed condition, its not-nearly-empty flag. Each upper queue also reports a full flag, which can only be read back.

Each group has the following:
- a 32-bit enable word;
- a 32-bit pending word that is cleared by writing ones to it;
- its own interrupt output.

A pending bit is set when the selected condition of an enabled queue goes from 0 to 1. A condition that simply stays high does not set it again. The status flags are registered on entry. Software reaches all registers through a plain word-addressed bus: a write strobe plus address and data, and a combinational read path. The status flags are level signals. They have no handshake, and the block never applies back-pressure to them.

Register map (word addresses):

| Address | Contents |
| --- | --- |
| 0 to 3 | Lower source words |
| 4 | Lower enable |
| 5 | Upper enable |
| 6 | Lower pending |
| 7 | Upper pending |
| 8 to 11 | Lower status readback |
| 12 | Upper not-nearly-empty readback |
| 13 | Upper full readback |
| 14, 15 | Read as zero |

Top module: `qsi_irq_ctrl`

## Requirements
- R1: While reset is held:
  - the source, enable and pending words read 0 and both interrupt lines are low;
  - lower status words 8..11 read 0x33333333, word 12 reads 0xFFFFFFFF and word 13 reads 0.
- R2: The source setting of lower queue q lives in word q/8 (addresses 0..3), in nibble q%8, bits [4*(q%8)+2 : 4*(q%8)]. Bit 3 of every nibble is reserved: it is not stored and always reads 0.
- R3: Flag selection works as follows:
  - source bits [1:0] pick the status flag that is tested: 0 = empty, 1 = nearly empty, 2 = nearly full, 3 = full;
  - flag k of lower queue q is input bit 4*q+k and reads back in word 8+q/8, bit 4*(q%8)+k;
  - flags that are not selected have no effect on pending.
- R4: Source bit 2 set to 1 inverts the selected flag before it is tested.
- R5: A pending bit is set only when its condition rises from 0 to 1 while its enable bit is 1. The set shows in the pending word two clock edges after the input change. A condition that is held high, or that rises while disabled, sets nothing, even if the queue is enabled later.
- R6: Upper queue 32+n uses bit n of words 5 and 7. Its condition is not-nearly-empty input bit n. The upper full flag reads back at word 13 and never sets pending.
- R7: Writing word 6 or 7 clears exactly the pending bits written as 1. Bits written as 0 keep their value.
- R8: When a set event and a clearing write hit the same pending bit in the same cycle, the bit ends up set.
- R9: Each interrupt line is high exactly while some pending bit of its group has its enable bit set. Clearing an enable bit drops that queue's part of the line but leaves its pending bit unchanged.
- R10: The two groups are independent: an upper event raises only the upper line, and a lower event raises only the lower line.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| lo_stat_i | input | 128 | Lower queue flags, 4 per queue (empty, nearly empty, nearly full, full) |
| hi_nne_i | input | 32 | Upper queue not-nearly-empty flags |
| hi_full_i | input | 32 | Upper queue full flags |
| irq_lo | output | 1 | Lower group interrupt |
| irq_hi | output | 1 | Upper group interrupt |

## Verification
Two functions can hit the same pending bit on the same clock edge: a set caused by a rising condition, and a clearing write to the pending word. The bench provokes this by raising an upper not-nearly-empty input at one falling edge and driving the clearing write at the next falling edge. The registered input path then puts both on the same rising edge. The bit must read back as set, while a clearing write with no coinciding event must still clear it.

// File: rtl/qsi_pkg.sv
`timescale 1ns/1ps
package qsi_pkg;

  localparam int SLOT_W = 4;
  localparam int SRC_W  = 3;

  typedef enum logic [1:0] {
    FLG_EMPTY      = 2'd0,
    FLG_NEAR_EMPTY = 2'd1,
    FLG_NEAR_FULL  = 2'd2,
    FLG_FULL       = 2'd3
  } flag_e;

  typedef struct packed {
    logic  inv;
    flag_e flag;
  } src_t;

  function automatic logic pick_cond(input logic [SLOT_W-1:0] nib, input src_t s);
    return nib[s.flag] ^ s.inv;
  endfunction

endpackage

// File: rtl/qsi_flop.sv
`timescale 1ns/1ps
module qsi_flop #(
  parameter int          W       = 32,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) q_o <= RST_VAL;
    else        q_o <= d_i;
  end
endmodule

// File: rtl/qsi_cond_sel.sv
`timescale 1ns/1ps
module qsi_cond_sel
  import qsi_pkg::*;
#(
  parameter int NQ = 32
) (
  input  logic [NQ*SLOT_W-1:0] stat_i,
  input  src_t [NQ-1:0]        src_i,
  output logic [NQ-1:0]        cond_o
);
  for (genvar q = 0; q < NQ; q++) begin : g_q
    assign cond_o[q] = pick_cond(stat_i[q*SLOT_W +: SLOT_W], src_i[q]);
  end
endmodule

// File: rtl/qsi_pend_bank.sv
`timescale 1ns/1ps
module qsi_pend_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cond_i,
  input  logic [W-1:0] en_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] pend_o,
  output logic         irq_o
);
  logic [W-1:0] cond_q;
  logic [W-1:0] pend_q;
  logic [W-1:0] set_ev;

  // rising condition of an enabled queue
  assign set_ev = cond_i & ~cond_q & en_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cond_q <= '0;
      pend_q <= '0;
    end else begin
      cond_q <= cond_i;
      pend_q <= (pend_q & ~clr_i) | set_ev;  // set has priority
    end
  end

  assign pend_o = pend_q;
  assign irq_o  = |(pend_q & en_i);

  p_w1c_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_i & ~set_ev)) |=> ((pend_q & $past(clr_i & ~set_ev)) == '0));

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_i & set_ev)) |=> ((pend_q & $past(clr_i & set_ev)) == $past(clr_i & set_ev)));

  p_set_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~$past(pend_q) & ~$past(en_i)) == '0));
endmodule

// File: rtl/qsi_regs.sv
`timescale 1ns/1ps
module qsi_regs
  import qsi_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 4,
  parameter int NQ = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [DW-1:0]        wdata_i,
  output logic [DW-1:0]        rdata_o,
  input  logic [NQ*SLOT_W-1:0] lo_stat_i,
  input  logic [NQ-1:0]        hi_nne_i,
  input  logic [NQ-1:0]        hi_full_i,
  input  logic [NQ-1:0]        pend_lo_i,
  input  logic [NQ-1:0]        pend_hi_i,
  output src_t [NQ-1:0]        src_o,
  output logic [NQ-1:0]        en_lo_o,
  output logic [NQ-1:0]        en_hi_o,
  output logic [NQ-1:0]        clr_lo_o,
  output logic [NQ-1:0]        clr_hi_o
);
  localparam int SPW       = DW / SLOT_W;
  localparam int SRC_WORDS = NQ / SPW;
  localparam int I_EN_LO   = SRC_WORDS;
  localparam int I_EN_HI   = SRC_WORDS + 1;
  localparam int I_PD_LO   = SRC_WORDS + 2;
  localparam int I_PD_HI   = SRC_WORDS + 3;
  localparam int I_ST0     = SRC_WORDS + 4;
  localparam int I_NNE     = I_ST0 + SRC_WORDS;
  localparam int I_FULL    = I_NNE + 1;
  localparam logic [AW-1:0] A_EN_LO = AW'(I_EN_LO);
  localparam logic [AW-1:0] A_EN_HI = AW'(I_EN_HI);
  localparam logic [AW-1:0] A_PD_LO = AW'(I_PD_LO);
  localparam logic [AW-1:0] A_PD_HI = AW'(I_PD_HI);
  localparam logic [AW-1:0] A_NNE   = AW'(I_NNE);
  localparam logic [AW-1:0] A_FULL  = AW'(I_FULL);
  localparam logic [DW-1:0] RSV_MASK = {SPW{4'b1000}};

  src_t [NQ-1:0] src_q;
  logic [NQ-1:0] en_lo_q;
  logic [NQ-1:0] en_hi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q   <= '0;
      en_lo_q <= '0;
      en_hi_q <= '0;
    end else if (we_i) begin
      for (int q = 0; q < NQ; q++) begin
        if (addr_i == AW'(q / SPW))
          src_q[q] <= src_t'(wdata_i[(q % SPW)*SLOT_W +: SRC_W]);
      end
      if (addr_i == A_EN_LO) en_lo_q <= wdata_i[NQ-1:0];
      if (addr_i == A_EN_HI) en_hi_q <= wdata_i[NQ-1:0];
    end
  end

  assign clr_lo_o = (we_i && addr_i == A_PD_LO) ? wdata_i[NQ-1:0] : '0;
  assign clr_hi_o = (we_i && addr_i == A_PD_HI) ? wdata_i[NQ-1:0] : '0;

  always_comb begin
    rdata_o = '0;
    for (int w = 0; w < SRC_WORDS; w++) begin
      if (addr_i == AW'(w)) begin
        for (int s = 0; s < SPW; s++)
          rdata_o[s*SLOT_W +: SRC_W] = src_q[w*SPW + s];
      end
      if (addr_i == AW'(I_ST0 + w))
        rdata_o = lo_stat_i[w*DW +: DW];
    end
    if (addr_i == A_EN_LO) rdata_o = en_lo_q;
    if (addr_i == A_EN_HI) rdata_o = en_hi_q;
    if (addr_i == A_PD_LO) rdata_o = pend_lo_i;
    if (addr_i == A_PD_HI) rdata_o = pend_hi_i;
    if (addr_i == A_NNE)   rdata_o = hi_nne_i;
    if (addr_i == A_FULL)  rdata_o = hi_full_i;
  end

  assign src_o   = src_q;
  assign en_lo_o = en_lo_q;
  assign en_hi_o = en_hi_q;

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i < A_EN_LO) |-> ((rdata_o & RSV_MASK) == '0));
endmodule

// File: rtl/qsi_irq_ctrl.sv
`timescale 1ns/1ps
module qsi_irq_ctrl
  import qsi_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [DW*4-1:0]  lo_stat_i,
  input  logic [DW-1:0]    hi_nne_i,
  input  logic [DW-1:0]    hi_full_i,
  output logic             irq_lo,
  output logic             irq_hi
);
  localparam int NQ = DW;

  logic [NQ*SLOT_W-1:0] lo_stat_q;
  logic [NQ-1:0]        hi_nne_q;
  logic [NQ-1:0]        hi_full_q;
  src_t [NQ-1:0]        src;
  logic [NQ-1:0]        en_lo, en_hi, clr_lo, clr_hi;
  logic [NQ-1:0]        cond_lo, pend_lo, pend_hi;

  qsi_flop #(.W(NQ*SLOT_W), .RST_VAL({NQ{4'h3}})) u_lo_stat (
    .clk(clk), .rst_n(rst_n), .d_i(lo_stat_i), .q_o(lo_stat_q));
  qsi_flop #(.W(NQ), .RST_VAL({NQ{1'b1}})) u_hi_nne (
    .clk(clk), .rst_n(rst_n), .d_i(hi_nne_i), .q_o(hi_nne_q));
  qsi_flop #(.W(NQ), .RST_VAL({NQ{1'b0}})) u_hi_full (
    .clk(clk), .rst_n(rst_n), .d_i(hi_full_i), .q_o(hi_full_q));

  qsi_regs #(.DW(DW), .AW(AW), .NQ(NQ)) u_regs (
    .clk(clk), .rst_n(rst_n), .we_i(bus_we), .addr_i(bus_addr),
    .wdata_i(bus_wdata), .rdata_o(bus_rdata),
    .lo_stat_i(lo_stat_q), .hi_nne_i(hi_nne_q), .hi_full_i(hi_full_q),
    .pend_lo_i(pend_lo), .pend_hi_i(pend_hi),
    .src_o(src), .en_lo_o(en_lo), .en_hi_o(en_hi),
    .clr_lo_o(clr_lo), .clr_hi_o(clr_hi));

  qsi_cond_sel #(.NQ(NQ)) u_sel (
    .stat_i(lo_stat_q), .src_i(src), .cond_o(cond_lo));

  qsi_pend_bank #(.W(NQ)) u_bank_lo (
    .clk(clk), .rst_n(rst_n), .cond_i(cond_lo), .en_i(en_lo),
    .clr_i(clr_lo), .pend_o(pend_lo), .irq_o(irq_lo));

  qsi_pend_bank #(.W(NQ)) u_bank_hi (
    .clk(clk), .rst_n(rst_n), .cond_i(hi_nne_q), .en_i(en_hi),
    .clr_i(clr_hi), .pend_o(pend_hi), .irq_o(irq_hi));

  p_irq_lo_pend_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_lo |-> ((pend_lo & en_lo) != '0));
  p_irq_hi_pend_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hi |-> ((pend_hi & en_hi) != '0));
endmodule

// File: tb/test_qsi_irq_ctrl.sv
`timescale 1ns/1ps
module test_qsi_irq_ctrl;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         bus_we;
  logic [3:0]   bus_addr;
  logic [31:0]  bus_wdata;
  logic [31:0]  bus_rdata;
  logic [127:0] lo_stat;
  logic [31:0]  hi_nne;
  logic [31:0]  hi_full;
  logic         irq_lo, irq_hi;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done  = 0;

  logic [31:0] exp_q[$];
  logic [3:0]  adr_q[$];
  logic        irq_q[$];
  string       req_q[$];
  event        mon_ev;

  always #2 clk = ~clk;

  qsi_irq_ctrl i_qsi_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lo_stat_i(lo_stat),
    .hi_nne_i(hi_nne), .hi_full_i(hi_full), .irq_lo(irq_lo), .irq_hi(irq_hi));

  // monitor: pops expected items and compares with the outputs
  initial begin
    forever begin
      logic [31:0] act, e;
      logic [3:0]  a;
      logic        is_irq;
      string       r;
      @(mon_ev);
      #0.5;
      e = exp_q.pop_front();
      a = adr_q.pop_front();
      is_irq = irq_q.pop_front();
      r = req_q.pop_front();
      act = is_irq ? {30'd0, irq_hi, irq_lo} : bus_rdata;
      n_cmp++;
      if (act !== e) begin
        n_bad++;
        if (is_irq) $display("FAIL %s irq lines actual=%h expected=%h", r, act, e);
        else $display("FAIL %s addr %0d actual=%h expected=%h", r, a, act, e);
      end
    end
  end

  task automatic check_reg(input logic [3:0] a, input logic [31:0] e, input string r);
    @(negedge clk);
    bus_addr = a;
    exp_q.push_back(e); adr_q.push_back(a); irq_q.push_back(1'b0); req_q.push_back(r);
    -> mon_ev;
    #1;
  endtask

  task automatic check_irq(input logic [1:0] e, input string r);
    @(negedge clk);
    exp_q.push_back({30'd0, e}); adr_q.push_back(4'd0); irq_q.push_back(1'b1); req_q.push_back(r);
    -> mon_ev;
    #1;
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic set_nib(input int q, input logic [3:0] v);
    @(negedge clk);
    lo_stat[q*4 +: 4] = v;
    settle();
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    lo_stat = '0; hi_nne = '0; hi_full = '1;
    repeat (3) @(negedge clk);
    // R1: reset values while reset is held
    check_reg(4'd0, 32'h0, "R1");
    check_reg(4'd4, 32'h0, "R1");
    check_reg(4'd5, 32'h0, "R1");
    check_reg(4'd6, 32'h0, "R1");
    check_reg(4'd7, 32'h0, "R1");
    check_reg(4'd8, 32'h33333333, "R1");
    check_reg(4'd11, 32'h33333333, "R1");
    check_reg(4'd12, 32'hFFFFFFFF, "R1");
    check_reg(4'd13, 32'h0, "R1");
    check_irq(2'b00, "R1");
    @(negedge clk) rst_n = 1'b1;
    settle();
    check_reg(4'd8, 32'h0, "R3");
    check_reg(4'd12, 32'h0, "R6");
    check_reg(4'd13, 32'hFFFFFFFF, "R6");

    // R2: slot layout and reserved bits
    bus_write(4'd1, 32'hFFFFFFFF);
    check_reg(4'd1, 32'h77777777, "R2");
    bus_write(4'd1, 32'h00000A00);
    check_reg(4'd1, 32'h00000200, "R2");
    check_reg(4'd0, 32'h0, "R2");
    bus_write(4'd1, 32'h0);

    // R3: flag readback and selection (queue 5, full flag)
    set_nib(5, 4'h8);
    check_reg(4'd8, 32'h00800000, "R3");
    bus_write(4'd0, 32'h00300000);
    bus_write(4'd4, 32'h00000020);
    settle();
    check_reg(4'd6, 32'h0, "R5");
    set_nib(5, 4'h0);
    set_nib(5, 4'h8);
    check_reg(4'd6, 32'h00000020, "R3");
    check_irq(2'b01, "R9");
    bus_write(4'd6, 32'h00000020);
    check_reg(4'd6, 32'h0, "R7");
    check_irq(2'b00, "R9");
    set_nib(5, 4'h4);
    set_nib(5, 4'h0);
    set_nib(5, 4'h4);
    check_reg(4'd6, 32'h0, "R3");

    // R4: inverted full flag
    bus_write(4'd4, 32'h0);
    set_nib(5, 4'h0);
    bus_write(4'd0, 32'h00700000);
    bus_write(4'd4, 32'h00000020);
    settle();
    check_reg(4'd6, 32'h0, "R4");
    set_nib(5, 4'h8);
    check_reg(4'd6, 32'h0, "R4");
    set_nib(5, 4'h0);
    check_reg(4'd6, 32'h00000020, "R4");

    // R9: disabling drops the line but keeps pending
    bus_write(4'd4, 32'h0);
    check_irq(2'b00, "R9");
    check_reg(4'd6, 32'h00000020, "R9");

    // R7: only ones clear
    bus_write(4'd6, 32'h00000010);
    check_reg(4'd6, 32'h00000020, "R7");
    bus_write(4'd6, 32'hFFFFFFFF);
    check_reg(4'd6, 32'h0, "R7");

    // R6 / R10: upper group
    bus_write(4'd5, 32'h00000008);
    @(negedge clk) hi_nne[3] = 1'b1;
    settle();
    check_reg(4'd7, 32'h00000008, "R6");
    check_irq(2'b10, "R10");
    check_reg(4'd6, 32'h0, "R10");
    bus_write(4'd5, 32'h00000018);
    @(negedge clk) hi_full[4] = 1'b0;
    settle();
    check_reg(4'd13, 32'hFFFFFFEF, "R6");
    @(negedge clk) hi_full[4] = 1'b1;
    settle();
    check_reg(4'd7, 32'h00000008, "R6");

    // R5: rise while disabled, later enable
    @(negedge clk) hi_nne[7] = 1'b1;
    settle();
    check_reg(4'd7, 32'h00000008, "R5");
    bus_write(4'd5, 32'h00000098);
    settle();
    check_reg(4'd7, 32'h00000008, "R5");

    // R8: set and clear on the same edge
    @(negedge clk) hi_nne[3] = 1'b0;
    settle();
    @(negedge clk) hi_nne[3] = 1'b1;
    bus_write(4'd7, 32'h00000008);
    check_reg(4'd7, 32'h00000008, "R8");
    bus_write(4'd7, 32'hFFFFFFFF);
    check_reg(4'd7, 32'h0, "R7");
    check_irq(2'b00, "R9");

    repeat (2) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule